// File: doc/BRIEF.md
# Register Stack with Full/Empty Flags

A last-in, first-out store built from a parameterised array of registers, with one write port for pushes and one registered output for pops. A top-of-stack pointer wraps modulo the depth. A push advances the pointer and writes into the slot it now names. A pop returns the word in the slot the pointer names, then steps the pointer back. The first word of an empty stack therefore sits in slot 1, and the word that fills the stack sits in slot 0.

The wrap of the pointer through zero drives two status flags. Pushing onto zero marks the stack full, and popping onto zero marks it empty. Requests that the stack cannot honour are refused with a one-cycle error pulse and change nothing: a push while full, a pop while empty, or a push and pop in the same cycle.

Top module: `reg_stack`

## Requirements
- R1: After reset the pointer is 0, empty is 1, full is 0, err is 0 and pop_data is 0.
- R2: An accepted push (push_req alone, full at 0) raises the pointer by one modulo the depth, writes push_data into the slot the new pointer names, and clears empty, all at the next clock edge.
- R3: An accepted push whose new pointer is 0 sets full. Starting from reset, the first pushed word goes to slot 1 and the word that fills the stack goes to slot 0.
- R4: An accepted pop (pop_req alone, empty at 0) places the word in the slot the pointer names on pop_data one cycle later, lowers the pointer by one modulo the depth, and clears full.
- R5: An accepted pop whose new pointer is 0 sets empty.
- R6: A push while full is refused. err is 1 for the following cycle, and the pointer, flags, array and pop_data are unchanged.
- R7: A pop while empty is refused the same way, with err 1 for one cycle and no state change.
- R8: push_req and pop_req together are refused with err for one cycle, even when either alone would be legal. Nothing is written and the pointer does not move.
- R9: Words come back in the reverse of the order in which they were pushed.
- R10: pop_data holds its value in every cycle without an accepted pop.
- R11: full and empty are never 1 at the same time, and err drops after one cycle unless another request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to push push_data |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DATA_W | Word to push |
| pop_data | output | DATA_W | Last popped word, registered |
| top_ptr | output | ADDR_W | Current top-of-stack pointer |
| full | output | 1 | Stack holds DEPTH words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench builds the stack with ADDR_W = 3 and DATA_W = 8, so it is eight words deep. With that depth a short vector walk can fill the stack, carry the pointer through the wrap from 7 to 0, and drain it back through the same wrap. The overflow, underflow and simultaneous-request refusals are each reached from a genuinely full or genuinely empty state. The array is cleared on reset in this build, and a mid-stream reset checks that every output returns to its reset value.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_PUSH   = 2'd1,
      OP_POP    = 2'd2,
      OP_REJECT = 2'd3
   } stk_op_e;

   function automatic stk_op_e decode_op(input logic push, input logic pop,
                                         input logic is_full, input logic is_empty);
      if (push && pop)           return OP_REJECT;
      else if (push && is_full)  return OP_REJECT;
      else if (pop && is_empty)  return OP_REJECT;
      else if (push)             return OP_PUSH;
      else if (pop)              return OP_POP;
      else                       return OP_IDLE;
   endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] top_ptr,
   output logic              full,
   output logic              empty,
   output logic              err
);
   localparam logic [ADDR_W-1:0] PTR_ZERO = '0;

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_up;
   logic [ADDR_W-1:0] ptr_dn;
   logic              full_q;
   logic              empty_q;
   logic              err_q;
   stk_op_e           op;

   always_comb begin
      op      = decode_op(push_req, pop_req, full_q, empty_q);
      ptr_up  = ptr_q + 1'b1;
      ptr_dn  = ptr_q - 1'b1;
      wr_en   = (op == OP_PUSH);
      wr_addr = ptr_up;
      rd_en   = (op == OP_POP);
      rd_addr = ptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= PTR_ZERO;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
         err_q   <= 1'b0;
      end else begin
         err_q <= (op == OP_REJECT);
         unique case (op)
            OP_PUSH: begin
               ptr_q   <= ptr_up;
               full_q  <= (ptr_up == PTR_ZERO);
               empty_q <= 1'b0;
            end
            OP_POP: begin
               ptr_q   <= ptr_dn;
               empty_q <= (ptr_dn == PTR_ZERO);
               full_q  <= 1'b0;
            end
            default: begin
               ptr_q <= ptr_q;
            end
         endcase
      end
   end

   assign top_ptr = ptr_q;
   assign full    = full_q;
   assign empty   = empty_q;
   assign err     = err_q;
endmodule

// File: rtl/stk_store.sv
module stk_store #(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_q;

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[rd_addr];
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/reg_stack.sv
module reg_stack #(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] pop_data,
   output logic [ADDR_W-1:0] top_ptr,
   output logic              full,
   output logic              empty,
   output logic              err
);
   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("reg_stack: ADDR_W must lie in 1..10");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("reg_stack: DATA_W must be at least 1");
      end
   endgenerate

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic              rd_en;
   logic [ADDR_W-1:0] rd_addr;

   stk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_req),
      .pop_req  (pop_req),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .top_ptr  (top_ptr),
      .full     (full),
      .empty    (empty),
      .err      (err)
   );

   stk_store #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (push_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (pop_data)
   );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_req,
   input logic              pop_req,
   input logic [DATA_W-1:0] pop_data,
   input logic [ADDR_W-1:0] top_ptr,
   input logic              full,
   input logic              empty,
   input logic              err
);
   logic refused;
   logic ok_push;
   logic ok_pop;
   assign refused = (push_req && pop_req) || (push_req && full) || (pop_req && empty);
   assign ok_push = push_req && !pop_req && !full;
   assign ok_pop  = pop_req && !push_req && !empty;

   // R2
   a_r2_push_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      ok_push |=> (top_ptr == ADDR_W'($past(top_ptr) + 1'b1)) && !empty);

   // R3
   a_r3_fill_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_push && (top_ptr == '1)) |=> full);

   // R4
   a_r4_pop_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      ok_pop |=> (top_ptr == ADDR_W'($past(top_ptr) - 1'b1)) && !full);

   // R5
   a_r5_drain_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_pop && (top_ptr == ADDR_W'(1))) |=> empty);

   // R6, R7, R8
   a_r8_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
      refused |=> err && $stable(top_ptr) && $stable(full) && $stable(empty) && $stable(pop_data));

   // R10
   a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_pop |=> $stable(pop_data));

   // R11
   a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      !refused |=> !err);
endmodule

bind reg_stack stk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stk_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .push_req (push_req),
   .pop_req  (pop_req),
   .pop_data (pop_data),
   .top_ptr  (top_ptr),
   .full     (full),
   .empty    (empty),
   .err      (err)
);

// File: tb/tb_reg_stack.sv
`timescale 1ns/1ps
module tb_reg_stack;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int NV = 22;

   typedef struct packed {
      logic          push;
      logic          pop;
      logic [DW-1:0] din;
      logic [AW-1:0] ptr;
      logic          full;
      logic          empty;
      logic          err;
      logic [DW-1:0] dout;
   } vec_t;

   // Expected state is what the outputs show after the clock edge that takes the request.
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,8'h11,3'd1,1'b0,1'b0,1'b0,8'h00}, // R2 R3 first word to slot 1
      '{1'b1,1'b0,8'h22,3'd2,1'b0,1'b0,1'b0,8'h00},
      '{1'b1,1'b0,8'h33,3'd3,1'b0,1'b0,1'b0,8'h00},
      '{1'b1,1'b0,8'h44,3'd4,1'b0,1'b0,1'b0,8'h00},
      '{1'b1,1'b0,8'h55,3'd5,1'b0,1'b0,1'b0,8'h00},
      '{1'b1,1'b0,8'h66,3'd6,1'b0,1'b0,1'b0,8'h00},
      '{1'b1,1'b0,8'h77,3'd7,1'b0,1'b0,1'b0,8'h00},
      '{1'b1,1'b0,8'h88,3'd0,1'b1,1'b0,1'b0,8'h00}, // R3 wrap to 0 sets full
      '{1'b1,1'b0,8'h99,3'd0,1'b1,1'b0,1'b1,8'h00}, // R6 overflow refused
      '{1'b0,1'b1,8'h00,3'd7,1'b0,1'b0,1'b0,8'h88}, // R4 R9 slot 0 comes back first
      '{1'b0,1'b1,8'h00,3'd6,1'b0,1'b0,1'b0,8'h77},
      '{1'b1,1'b1,8'hAA,3'd6,1'b0,1'b0,1'b1,8'h77}, // R8 both requests refused
      '{1'b0,1'b0,8'hBB,3'd6,1'b0,1'b0,1'b0,8'h77}, // R10 R11 idle, err gone
      '{1'b0,1'b1,8'h00,3'd5,1'b0,1'b0,1'b0,8'h66}, // R8 R9 nothing written by refused push
      '{1'b0,1'b1,8'h00,3'd4,1'b0,1'b0,1'b0,8'h55},
      '{1'b0,1'b1,8'h00,3'd3,1'b0,1'b0,1'b0,8'h44},
      '{1'b0,1'b1,8'h00,3'd2,1'b0,1'b0,1'b0,8'h33},
      '{1'b0,1'b1,8'h00,3'd1,1'b0,1'b0,1'b0,8'h22},
      '{1'b0,1'b1,8'h00,3'd0,1'b0,1'b1,1'b0,8'h11}, // R5 drain to 0 sets empty
      '{1'b0,1'b1,8'h00,3'd0,1'b0,1'b1,1'b1,8'h11}, // R7 underflow refused
      '{1'b1,1'b0,8'h5A,3'd1,1'b0,1'b0,1'b0,8'h11}, // R2 R10
      '{1'b0,1'b1,8'h00,3'd0,1'b0,1'b1,1'b0,8'h5A}  // R4 R5
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_req = 1'b0;
   logic          pop_req = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] pop_data;
   logic [AW-1:0] top_ptr;
   logic          full;
   logic          empty;
   logic          err;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   reg_stack #(.ADDR_W(AW), .DATA_W(DW), .CLEAR_ON_RESET(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .push_data (push_data),
      .pop_data  (pop_data),
      .top_ptr   (top_ptr),
      .full      (full),
      .empty     (empty),
      .err       (err)
   );

   task automatic check_state(input string tag, input logic [AW-1:0] eptr,
                              input logic efull, input logic eempty,
                              input logic eerr, input logic [DW-1:0] edout);
      n_checks++;
      if (top_ptr !== eptr || full !== efull || empty !== eempty ||
          err !== eerr || pop_data !== edout) begin
         n_fails++;
         $display("FAIL %s: got ptr=%0d full=%b empty=%b err=%b data=%h, expected ptr=%0d full=%b empty=%b err=%b data=%h",
                  tag, top_ptr, full, empty, err, pop_data,
                  eptr, efull, eempty, eerr, edout);
      end
   endtask

   task automatic apply(input logic p, input logic q, input logic [DW-1:0] d);
      push_req  = p;
      pop_req   = q;
      push_data = d;
      @(posedge clk);
      @(negedge clk);
      push_req = 1'b0;
      pop_req  = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000 && !done) begin
         n_fails = n_fails + 1;
         $display("FAIL watchdog: got no finish, expected finish within 5000 cycles");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_state("R1 reset", '0, 1'b0, 1'b1, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after release", '0, 1'b0, 1'b1, 1'b0, '0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].push, VEC[i].pop, VEC[i].din);
         check_state($sformatf("vector %0d (R2..R11)", i),
                     VEC[i].ptr, VEC[i].full, VEC[i].empty, VEC[i].err, VEC[i].dout);
      end

      // R8: simultaneous requests on an empty stack write nothing
      apply(1'b1, 1'b1, 8'hC3);
      check_state("R8 both while empty", '0, 1'b0, 1'b1, 1'b1, 8'h5A);
      apply(1'b0, 1'b0, 8'h00);
      check_state("R11 err one cycle", '0, 1'b0, 1'b1, 1'b0, 8'h5A);

      // R3 R9: refill completely, then the top pop returns the slot-0 word
      for (int k = 0; k < 8; k++) apply(1'b1, 1'b0, DW'(8'hE0 + k));
      check_state("R3 refilled full", '0, 1'b1, 1'b0, 1'b0, 8'h5A);
      apply(1'b0, 1'b1, 8'h00);
      check_state("R9 last in first out", 3'd7, 1'b0, 1'b0, 1'b0, 8'hE7);

      // R1: reset in mid stream
      apply(1'b1, 1'b0, 8'h42);
      rst_n = 1'b0;
      @(negedge clk);
      check_state("R1 mid-stream reset", '0, 1'b0, 1'b1, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      apply(1'b0, 1'b1, 8'h00);
      check_state("R7 pop after reset refused", '0, 1'b0, 1'b1, 1'b1, '0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule